// File: doc/BRIEF.md
# Bulk Endpoint Pair Ownership and Handshake Controller

This block decides who owns each of two bulk endpoint buffers, one transmitting toward the host (IN) and one receiving from it (OUT). A buffer belongs either to the CPU firmware or to the USB serial engine. An ownership flag per endpoint, called BUSY, records which side holds it. Firmware hands a buffer to the USB side by writing that endpoint's byte count register. The serial engine hands it back by reporting a completed transfer. Firmware can also take back an armed IN buffer by writing 1 to its busy bit. Each endpoint has an interrupt flag, and that flag is set only when BUSY falls.

The serial engine presents each token as a one-cycle pulse. One cycle later the block answers with a handshake decision: ACK, NAK or STALL. A per-endpoint STALL bit, set by the CPU, overrides the ACK/NAK decision. A side port reports the stall state of an endpoint for a Get Status endpoint query. Bit 7 of the endpoint number supplied to that port picks the direction.

The CPU map has four 8-bit registers. Address 0 is IN control and address 1 is OUT control. In both, bit 0 is STALL (read/write), bit 1 is BUSY and bit 2 is the interrupt flag (write 1 to clear). Address 2 is the IN byte count and address 3 is the OUT byte count. The low `CNT_W` bits hold the count and the upper bits read as 0.

Top module: `bulk_ep_pair_ctrl`

## Requirements
- R1: After reset, both BUSY bits, both STALL bits, both interrupt flags and both byte counts read 0, and `irq_in`, `irq_out` and `hs_valid` are 0.
- R2: A write to address 2 stores the low `CNT_W` bits of the data as the IN byte count, shown on `in_len` and at address 2, and sets IN BUSY to 1.
- R3: A write of any value to address 3 sets OUT BUSY to 1 and leaves the OUT byte count unchanged.
- R4: A token pulse sampled at one edge gives `hs_valid`=1 after the next edge. While the addressed endpoint is not stalled, the answer is ACK (code 0) if its BUSY is 1 and NAK (code 1) if its BUSY is 0. BUSY is the value before that edge. `tok_in`=1 means an IN token.
- R5: While bit 0 of an endpoint's control register is 1, every token for that endpoint is answered with STALL (code 2). Writing the STALL bit never changes BUSY.
- R6: A completion with `done_in`=1 clears IN BUSY. A completion for an endpoint whose BUSY is 0 changes nothing.
- R7: A completion with `done_in`=0 while OUT BUSY is 1 clears OUT BUSY and loads `done_len` into the OUT byte count.
- R8: Writing 1 to bit 1 at address 0 clears IN BUSY (disarm). Writing bit 1 at address 1 has no effect on OUT BUSY.
- R9: An endpoint's interrupt flag is set on every 1-to-0 change of its BUSY, including a disarm, and on no other event. It stays set until a write with bit 2 = 1 to its control register. A set and a clear in the same cycle leave the flag set.
- R10: A byte count write in the same cycle as a completion for the same endpoint leaves BUSY at 1 and does not set the interrupt flag.
- R11: `gs_stall` shows the IN STALL bit when `gs_ep[7]` is 1 and the OUT STALL bit when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU register write strobe |
| cpu_addr | input | 2 | CPU register address |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data for `cpu_addr` (combinational) |
| tok_valid | input | 1 | Token pulse from the serial engine |
| tok_in | input | 1 | Token direction, 1 = IN |
| done_valid | input | 1 | Transfer completion pulse |
| done_in | input | 1 | Completion direction, 1 = IN |
| done_len | input | CNT_W | Received length for an OUT completion |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| in_len | output | CNT_W | Armed IN byte count for the serial engine |
| irq_in | output | 1 | IN endpoint interrupt flag |
| irq_out | output | 1 | OUT endpoint interrupt flag |
| gs_ep | input | 8 | Endpoint number of a Get Status query |
| gs_stall | output | 1 | STALL state of the queried endpoint |

## Verification
The hardest case to reach from the ports is two events landing in the same clock cycle. One is a byte count write that collides with a completion on the same endpoint. The other is a flag clear that collides with a BUSY fall; this can only happen through a completion or a disarm issued in that very cycle. Random traffic seldom lines these up while BUSY is 1. The bench therefore drives directed sequences that first arm the endpoint and then issue the colliding pair. Weighted random traffic with a fixed seed then covers stall, token and completion mixtures against a bench model.

// File: rtl/ep_pkg.sv
package ep_pkg;
   typedef enum logic [1:0] {
      HS_ACK   = 2'b00,
      HS_NAK   = 2'b01,
      HS_STALL = 2'b10
   } hs_t;

   localparam logic [1:0] A_IN_CTRL  = 2'd0;
   localparam logic [1:0] A_OUT_CTRL = 2'd1;
   localparam logic [1:0] A_IN_CNT   = 2'd2;
   localparam logic [1:0] A_OUT_CNT  = 2'd3;

   localparam int B_STALL = 0;
   localparam int B_BUSY  = 1;
   localparam int B_IRQ   = 2;
endpackage

// File: rtl/ep_slot.sv
module ep_slot #(
   parameter int CNT_W = 7,
   parameter bit IS_IN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic             w_stall,
   input  logic             w_busy,
   input  logic             w_irq,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             done,
   input  logic [CNT_W-1:0] done_len,
   output logic             busy,
   output logic             stall,
   output logic             irq,
   output logic [CNT_W-1:0] cnt
);
   logic busy_d, disarm, finish;

   assign finish = done & busy;

   generate
      if (IS_IN) begin : g_in
         assign disarm = ctrl_we & w_busy;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (cnt_we) cnt <= cnt_wdata;
         end
      end else begin : g_out
         assign disarm = 1'b0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (finish) cnt <= done_len;
         end
      end
   endgenerate

   always_comb begin
      busy_d = busy;
      if (finish || disarm) busy_d = 1'b0;
      if (cnt_we)           busy_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         stall <= 1'b0;
         irq   <= 1'b0;
      end else begin
         busy <= busy_d;
         if (ctrl_we) stall <= w_stall;
         if (busy && !busy_d)      irq <= 1'b1;
         else if (ctrl_we && w_irq) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/hs_decide.sv
module hs_decide
   import ep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tok_valid,
   input  logic       tok_in,
   input  logic       in_busy,
   input  logic       in_stall,
   input  logic       out_busy,
   input  logic       out_stall,
   output logic       hs_valid,
   output logic [1:0] hs_code
);
   hs_t code_d;
   logic sel_busy, sel_stall;

   assign sel_busy  = tok_in ? in_busy  : out_busy;
   assign sel_stall = tok_in ? in_stall : out_stall;

   always_comb begin
      if (sel_stall)     code_d = HS_STALL;
      else if (sel_busy) code_d = HS_ACK;
      else               code_d = HS_NAK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_valid <= 1'b0;
         hs_code  <= HS_ACK;
      end else begin
         hs_valid <= tok_valid;
         if (tok_valid) hs_code <= code_d;
      end
   end
endmodule

// File: rtl/bulk_ep_pair_ctrl.sv
module bulk_ep_pair_ctrl
   import ep_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              tok_valid,
   input  logic              tok_in,
   input  logic              done_valid,
   input  logic              done_in,
   input  logic [CNT_W-1:0]  done_len,
   output logic              hs_valid,
   output logic [1:0]        hs_code,
   output logic [CNT_W-1:0]  in_len,
   output logic              irq_in,
   output logic              irq_out,
   input  logic [7:0]        gs_ep,
   output logic              gs_stall
);
   localparam int PAD_W = DATA_W - CNT_W;

   generate
      if (DATA_W < 3)       begin : g_bad_data $error("DATA_W must hold three control bits"); end
      if (CNT_W < 1)        begin : g_bad_cnt  $error("CNT_W must be at least 1"); end
      if (CNT_W > DATA_W)   begin : g_bad_fit  $error("CNT_W must not exceed DATA_W"); end
   endgenerate

   logic in_busy, in_stall, out_busy, out_stall;
   logic [CNT_W-1:0] out_cnt;
   logic we_in_ctrl, we_out_ctrl, we_in_cnt, we_out_cnt;

   assign we_in_ctrl  = cpu_we && cpu_addr == A_IN_CTRL;
   assign we_out_ctrl = cpu_we && cpu_addr == A_OUT_CTRL;
   assign we_in_cnt   = cpu_we && cpu_addr == A_IN_CNT;
   assign we_out_cnt  = cpu_we && cpu_addr == A_OUT_CNT;

   ep_slot #(.CNT_W(CNT_W), .IS_IN(1'b1)) u_in (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(we_in_ctrl), .w_stall(cpu_wdata[B_STALL]),
      .w_busy(cpu_wdata[B_BUSY]), .w_irq(cpu_wdata[B_IRQ]),
      .cnt_we(we_in_cnt), .cnt_wdata(cpu_wdata[CNT_W-1:0]),
      .done(done_valid && done_in), .done_len(done_len),
      .busy(in_busy), .stall(in_stall), .irq(irq_in), .cnt(in_len)
   );

   ep_slot #(.CNT_W(CNT_W), .IS_IN(1'b0)) u_out (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(we_out_ctrl), .w_stall(cpu_wdata[B_STALL]),
      .w_busy(cpu_wdata[B_BUSY]), .w_irq(cpu_wdata[B_IRQ]),
      .cnt_we(we_out_cnt), .cnt_wdata(cpu_wdata[CNT_W-1:0]),
      .done(done_valid && !done_in), .done_len(done_len),
      .busy(out_busy), .stall(out_stall), .irq(irq_out), .cnt(out_cnt)
   );

   hs_decide u_hs (
      .clk(clk), .rst_n(rst_n),
      .tok_valid(tok_valid), .tok_in(tok_in),
      .in_busy(in_busy), .in_stall(in_stall),
      .out_busy(out_busy), .out_stall(out_stall),
      .hs_valid(hs_valid), .hs_code(hs_code)
   );

   assign gs_stall = gs_ep[7] ? in_stall : out_stall;

   logic [DATA_W-1:0] in_cnt_ext, out_cnt_ext;
   generate
      if (PAD_W > 0) begin : g_pad
         assign in_cnt_ext  = {{PAD_W{1'b0}}, in_len};
         assign out_cnt_ext = {{PAD_W{1'b0}}, out_cnt};
      end else begin : g_nopad
         assign in_cnt_ext  = in_len;
         assign out_cnt_ext = out_cnt;
      end
   endgenerate

   always_comb begin
      cpu_rdata = '0;
      case (cpu_addr)
         A_IN_CTRL: begin
            cpu_rdata[B_STALL] = in_stall;
            cpu_rdata[B_BUSY]  = in_busy;
            cpu_rdata[B_IRQ]   = irq_in;
         end
         A_OUT_CTRL: begin
            cpu_rdata[B_STALL] = out_stall;
            cpu_rdata[B_BUSY]  = out_busy;
            cpu_rdata[B_IRQ]   = irq_out;
         end
         A_IN_CNT: cpu_rdata = in_cnt_ext;
         default:  cpu_rdata = out_cnt_ext;
      endcase
   end
endmodule

// File: rtl/bulk_ep_pair_ctrl_chk.sv
module bulk_ep_pair_ctrl_chk #(
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_we,
   input logic [1:0]       cpu_addr,
   input logic             tok_valid,
   input logic             tok_in,
   input logic             done_valid,
   input logic             done_in,
   input logic [CNT_W-1:0] done_len,
   input logic             hs_valid,
   input logic [1:0]       hs_code,
   input logic             in_busy,
   input logic             in_stall,
   input logic             out_busy,
   input logic             out_stall,
   input logic             irq_in,
   input logic             irq_out,
   input logic [CNT_W-1:0] out_cnt
);
   // R2
   arm_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && cpu_addr == 2'd2) |=> in_busy);

   // R4
   in_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_in && !in_stall && !in_busy) |=> (hs_valid && hs_code == 2'd1));

   // R5
   stall_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && (tok_in ? in_stall : out_stall)) |=> (hs_valid && hs_code == 2'd2));

   // R7
   out_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !done_in && out_busy && !(cpu_we && cpu_addr == 2'd3))
         |=> (!out_busy && out_cnt == $past(done_len)));

   // R9
   irq_in_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_in) |-> $fell(in_busy));

   // R9
   irq_out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> $fell(out_busy));
endmodule

bind bulk_ep_pair_ctrl bulk_ep_pair_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .tok_valid(tok_valid), .tok_in(tok_in),
   .done_valid(done_valid), .done_in(done_in), .done_len(done_len),
   .hs_valid(hs_valid), .hs_code(hs_code),
   .in_busy(in_busy), .in_stall(in_stall),
   .out_busy(out_busy), .out_stall(out_stall),
   .irq_in(irq_in), .irq_out(irq_out), .out_cnt(out_cnt)
);

// File: tb/bulk_ep_pair_ctrl_tb.sv
`timescale 1ns/1ps
module bulk_ep_pair_ctrl_tb;
   localparam int DW = 8;
   localparam int CW = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_we = 1'b0;
   logic [1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic tok_valid = 1'b0, tok_in = 1'b0;
   logic done_valid = 1'b0, done_in = 1'b0;
   logic [CW-1:0] done_len = '0;
   logic hs_valid;
   logic [1:0] hs_code;
   logic [CW-1:0] in_len;
   logic irq_in, irq_out;
   logic [7:0] gs_ep = '0;
   logic gs_stall;

   always #2 clk = ~clk;

   bulk_ep_pair_ctrl #(.DATA_W(DW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .tok_valid(tok_valid), .tok_in(tok_in),
      .done_valid(done_valid), .done_in(done_in), .done_len(done_len),
      .hs_valid(hs_valid), .hs_code(hs_code), .in_len(in_len),
      .irq_in(irq_in), .irq_out(irq_out), .gs_ep(gs_ep), .gs_stall(gs_stall)
   );

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   // bench model, index 1 = IN, 0 = OUT
   bit m_busy [2];
   bit m_stall[2];
   bit m_irq  [2];
   logic [CW-1:0] m_cnt[2];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
      logic [DW-1:0] r = '0;
      if (a < 2'd2) begin
         r[0] = m_stall[a == 2'd0];
         r[1] = m_busy[a == 2'd0];
         r[2] = m_irq[a == 2'd0];
      end else begin
         r[CW-1:0] = m_cnt[a == 2'd2];
      end
      return r;
   endfunction

   function automatic logic [1:0] exp_hs(input bit dir);
      if (m_stall[dir]) return 2'd2;
      if (m_busy[dir])  return 2'd0;
      return 2'd1;
   endfunction

   task automatic step(input bit we, input logic [1:0] a, input logic [DW-1:0] wd,
                       input bit tk, input bit tkin, input bit dn, input bit dnin,
                       input logic [CW-1:0] ln, input logic [7:0] gs, input string req);
      bit pb[2];
      bit nb;
      logic [1:0] hs_e;
      @(negedge clk);
      cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      tok_valid = tk; tok_in = tkin;
      done_valid = dn; done_in = dnin; done_len = ln; gs_ep = gs;
      #1;
      chk(cpu_rdata == exp_read(a), {req, " readback"}, cpu_rdata, exp_read(a));
      hs_e = exp_hs(tkin);
      pb = m_busy;
      for (int e = 0; e < 2; e++) begin
         nb = m_busy[e];
         if (dn && (dnin == e[0]) && pb[e]) begin
            nb = 1'b0;
            if (e == 0) m_cnt[0] = ln;
         end
         if (e == 1 && we && a == 2'd0 && wd[1]) nb = 1'b0;
         if (we && a == (e == 1 ? 2'd2 : 2'd3)) begin
            nb = 1'b1;
            if (e == 1) m_cnt[1] = wd[CW-1:0];
         end
         if (we && a == (e == 1 ? 2'd0 : 2'd1)) begin
            m_stall[e] = wd[0];
            if (wd[2]) m_irq[e] = 1'b0;
         end
         if (pb[e] && !nb) m_irq[e] = 1'b1;
         m_busy[e] = nb;
      end
      @(posedge clk);
      #1;
      chk(hs_valid == tk, "R4 hs_valid", hs_valid, tk);
      if (tk) chk(hs_code == hs_e, (m_stall[tkin] ? "R5 stall code" : "R4 code"), hs_code, hs_e);
      chk(irq_in == m_irq[1], "R9 irq_in", irq_in, m_irq[1]);
      chk(irq_out == m_irq[0], "R9 irq_out", irq_out, m_irq[0]);
      chk(in_len == m_cnt[1], "R2 in_len", in_len, m_cnt[1]);
      chk(gs_stall == m_stall[gs[7]], "R11 gs_stall", gs_stall, m_stall[gs[7]]);
      cpu_we = 1'b0; tok_valid = 1'b0; done_valid = 1'b0;
   endtask

   task automatic idle(input logic [1:0] a, input string req);
      step(1'b0, a, '0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 8'h00, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      int seed;
      for (int e = 0; e < 2; e++) begin
         m_busy[e] = 0; m_stall[e] = 0; m_irq[e] = 0; m_cnt[e] = '0;
      end
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1 reset state of every register and output
      #1;
      chk(hs_valid == 1'b0, "R1 hs_valid", hs_valid, 0);
      for (int a = 0; a < 4; a++) idle(a[1:0], "R1");

      // R4 NAK on both endpoints while unarmed
      step(0, 0, 0, 1, 1, 0, 0, 0, 0, "R4");
      step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R4");
      // R2 arm IN with a count, then ACK
      step(1, 2, 8'h2A, 0, 0, 0, 0, 0, 0, "R2");
      idle(0, "R2");
      idle(2, "R2");
      step(0, 0, 0, 1, 1, 0, 0, 0, 0, "R4");
      // R6 completion for unarmed OUT ignored
      step(0, 0, 0, 0, 0, 1, 0, 7'd9, 0, "R6");
      idle(3, "R6");
      idle(1, "R6");
      // R6 IN completion clears busy, R9 irq set
      step(0, 0, 0, 0, 0, 1, 1, 0, 0, "R6");
      idle(0, "R6");
      // R9 clear irq by write 1 to bit 2, stall 0
      step(1, 0, 8'h04, 0, 0, 0, 0, 0, 0, "R9");
      idle(0, "R9");
      // R3 arm OUT with arbitrary value, count unchanged
      step(1, 3, 8'h55, 0, 0, 0, 0, 0, 0, "R3");
      idle(3, "R3");
      idle(1, "R3");
      // R7 OUT completion latches length
      step(0, 0, 0, 1, 0, 1, 0, 7'd37, 0, "R7");
      idle(3, "R7");
      // R8 disarm IN raises irq; OUT busy bit write ignored
      step(1, 2, 8'h10, 0, 0, 0, 0, 0, 0, "R8");
      step(1, 0, 8'h02, 0, 0, 0, 0, 0, 0, "R8");
      idle(0, "R8");
      step(1, 3, 8'h00, 0, 0, 0, 0, 0, 0, "R8");
      step(1, 1, 8'h02, 0, 0, 0, 0, 0, 0, "R8");
      idle(1, "R8");
      // R9 set wins over clear: OUT completion and clear in same cycle
      step(1, 1, 8'h04, 0, 0, 1, 0, 7'd3, 0, "R9");
      idle(1, "R9");
      // R10 arm and completion in same cycle
      step(1, 2, 8'h07, 0, 0, 0, 0, 0, 0, "R10");
      step(1, 0, 8'h04, 0, 0, 0, 0, 0, 0, "R10");
      step(1, 2, 8'h08, 0, 0, 1, 1, 0, 0, "R10");
      idle(0, "R10");
      // R5 stall both, busy kept, stall handshake, R11 status
      step(1, 0, 8'h01, 1, 1, 0, 0, 0, 8'h81, "R5");
      idle(0, "R5");
      step(0, 0, 0, 1, 1, 0, 0, 0, 8'h81, "R5");
      step(1, 1, 8'h01, 1, 0, 0, 0, 0, 8'h01, "R11");
      step(0, 0, 0, 1, 0, 0, 0, 0, 8'h01, "R5");
      step(1, 0, 8'h00, 0, 0, 0, 0, 0, 8'h81, "R11");
      step(1, 1, 8'h00, 0, 0, 0, 0, 0, 8'h02, "R11");

      // weighted random traffic
      seed = $urandom(32'h5EED_0B1C);
      for (int i = 0; i < 3000; i++) begin
         bit we, tk, dn;
         logic [1:0] a;
         logic [DW-1:0] wd;
         we = ($urandom_range(0, 99) < 30);
         a  = 2'($urandom_range(0, 3));
         wd = 8'($urandom);
         if (a < 2) wd[0] = ($urandom_range(0, 99) < 15);
         tk = ($urandom_range(0, 99) < 40);
         dn = ($urandom_range(0, 99) < 25);
         step(we, a, wd, tk, 1'($urandom), dn, 1'($urandom), 7'($urandom),
              8'($urandom), "R4/R9 random");
      end

      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule